// File: doc/BRIEF.md
# Size-Aware Minimal-Value Victim Selector

This block manages replacement for one set of a compressed cache. It holds a small tag-side record for every way of the set: whether the way is occupied, a 2-bit re-reference prediction counter, and the compressed size of the resident block counted in 8-byte segments. On a miss it names the way to evict, and at the same time it records the incoming block in that way. On a hit it marks the hit way as likely to be reused soon.

Each occupied way is given a worth equal to its estimated chance of reuse divided by its size in segments. The chance of reuse comes from a fixed four-entry weight table that is indexed by the way's counter. The way of least worth is evicted, so a large block that is unlikely to be reused leaves first. The comparison multiplies each weight by the other way's size, so no divider is needed. The default geometry is an 8-way tag array. A compressed set holds twice as many tags as an uncompressed set, so these 8 ways stand in for 4 uncompressed ones.

Top module: `vsel_top`

## Requirements
- R1: After reset every way is empty and `victim_valid` is low.
- R2: A request with `req_hit` low (a miss) sets `victim_valid` high for exactly the one cycle after the request edge, and `victim_way` holds the chosen way during that cycle. A request with `req_hit` high never raises `victim_valid`.
- R3: While any way is empty, the victim is the empty way with the lowest index, ahead of every occupied way.
- R4: When all ways are occupied, the victim is the way with the smallest weight/size. The weight is 8, 4, 2 or 1 for counter values 0, 1, 2 and 3.
- R5: When two or more occupied ways share the smallest worth, the one with the lowest index is evicted.
- R6: A hit request sets the counter of way `req_way` to 0. This raises the weight of that way to 8.
- R7: On a miss, the victim way becomes occupied, its counter is set to 2 and it takes the incoming size.
- R8: An incoming size of 0 is stored as 1 segment. An incoming size above 8 is stored as 8 segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_hit | input | 1 | 1: hit on `req_way`; 0: miss with fill |
| req_way | input | 3 | Way that hit |
| req_size | input | 4 | Compressed size of the incoming block, in segments |
| victim_valid | output | 1 | One-cycle pulse after a miss |
| victim_way | output | 3 | Way evicted and refilled |

## Verification
The bench builds the block with its defaults: 8 ways, 2-bit counters, 8-segment maximum size and the 8/4/2/1 weight table. These values let every way be filled, then refilled with sizes spanning the whole 1 to 8 range. They also let a counter-0 block of 8 segments tie exactly with a counter-2 block of 2 segments, which shows that the comparison is by cross-products and not by counter or size alone. The 4-bit size input can carry 0 and values above 8, so both clamp paths can be reached.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int RRPV_W   = 2;
  localparam int PROB_W   = 4;
  localparam int RRPV_INS = 2;
  localparam int RRPV_HIT = 0;
  typedef logic [RRPV_W-1:0] rrpv_t;
endpackage

// File: rtl/vsel_way_entry.sv
module vsel_way_entry
  import vsel_pkg::*;
#(
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic             fill_en,
  input  logic [SEG_W-1:0] fill_seg,
  output logic             occ,
  output rrpv_t            rrpv,
  output logic [SEG_W-1:0] seg
);
  logic             occ_d;
  rrpv_t            rrpv_d;
  logic [SEG_W-1:0] seg_d;
  logic             upd_en;

  assign upd_en = hit_en | fill_en;

  always_comb begin
    occ_d  = occ;
    rrpv_d = rrpv;
    seg_d  = seg;
    if (fill_en) begin
      occ_d  = 1'b1;
      rrpv_d = rrpv_t'(RRPV_INS);
      seg_d  = fill_seg;
    end else if (hit_en) begin
      rrpv_d = rrpv_t'(RRPV_HIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= 1'b0;
      rrpv <= '0;
      seg  <= '0;
    end else if (upd_en) begin
      occ  <= occ_d;
      rrpv <= rrpv_d;
      seg  <= seg_d;
    end
  end
endmodule

// File: rtl/vsel_min_chain.sv
module vsel_min_chain
  import vsel_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SEG_W = 4,
  parameter logic [4*PROB_W-1:0] PROB_TABLE = {4'd1, 4'd2, 4'd4, 4'd8},
  localparam int WAY_W = $clog2(WAYS),
  localparam int PRD_W = PROB_W + SEG_W
) (
  input  logic [WAYS-1:0]        occ_vec,
  input  logic [WAYS*RRPV_W-1:0] rrpv_vec,
  input  logic [WAYS*SEG_W-1:0]  seg_vec,
  output logic [WAY_W-1:0]       best_way
);
  logic [WAY_W-1:0]  st_idx [WAYS];
  logic              st_occ [WAYS];
  logic [PROB_W-1:0] st_w   [WAYS];
  logic [SEG_W-1:0]  st_s   [WAYS];
  logic [PROB_W-1:0] way_w  [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_wt
    assign way_w[g] = PROB_TABLE[rrpv_vec[g*RRPV_W +: RRPV_W]*PROB_W +: PROB_W];
  end

  assign st_idx[0] = '0;
  assign st_occ[0] = occ_vec[0];
  assign st_w[0]   = way_w[0];
  assign st_s[0]   = seg_vec[0 +: SEG_W];

  for (genvar g = 1; g < WAYS; g++) begin : g_stage
    logic [PRD_W-1:0] lhs, rhs;
    logic             take;
    assign lhs  = PRD_W'(way_w[g]) * PRD_W'(st_s[g-1]);
    assign rhs  = PRD_W'(st_w[g-1]) * PRD_W'(seg_vec[g*SEG_W +: SEG_W]);
    assign take = (st_occ[g-1] && !occ_vec[g]) ||
                  (st_occ[g-1] && occ_vec[g] && (lhs < rhs));
    assign st_idx[g] = take ? WAY_W'(g) : st_idx[g-1];
    assign st_occ[g] = take ? occ_vec[g] : st_occ[g-1];
    assign st_w[g]   = take ? way_w[g] : st_w[g-1];
    assign st_s[g]   = take ? seg_vec[g*SEG_W +: SEG_W] : st_s[g-1];
  end

  assign best_way = st_idx[WAYS-1];
endmodule

// File: rtl/vsel_top.sv
module vsel_top
  import vsel_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int MAX_SEG = 8,
  parameter logic [4*PROB_W-1:0] PROB_TABLE = {4'd1, 4'd2, 4'd4, 4'd8},
  localparam int WAY_W = $clog2(WAYS),
  localparam int SEG_W = $clog2(MAX_SEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_way,
  input  logic [SEG_W-1:0] req_size,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic                   rst_meta, rst_q;
  logic [SEG_W-1:0]       seg_in;
  logic                   miss_req, hit_req;
  logic [WAYS-1:0]        way_occ;
  logic [WAYS*RRPV_W-1:0] way_rrpv;
  logic [WAYS*SEG_W-1:0]  way_seg;
  logic [WAY_W-1:0]       pick;
  logic                   vld_d;
  logic [WAY_W-1:0]       way_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    if (req_size == '0)
      seg_in = SEG_W'(1);
    else if (req_size > SEG_W'(MAX_SEG))
      seg_in = SEG_W'(MAX_SEG);
    else
      seg_in = req_size;
  end

  assign miss_req = req_valid & ~req_hit;
  assign hit_req  = req_valid &  req_hit;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    vsel_way_entry #(.SEG_W(SEG_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_q),
      .hit_en   (hit_req && (req_way == WAY_W'(g))),
      .fill_en  (miss_req && (pick == WAY_W'(g))),
      .fill_seg (seg_in),
      .occ      (way_occ[g]),
      .rrpv     (way_rrpv[g*RRPV_W +: RRPV_W]),
      .seg      (way_seg[g*SEG_W +: SEG_W])
    );
  end

  vsel_min_chain #(
    .WAYS(WAYS), .SEG_W(SEG_W), .PROB_TABLE(PROB_TABLE)
  ) u_chain (
    .occ_vec  (way_occ),
    .rrpv_vec (way_rrpv),
    .seg_vec  (way_seg),
    .best_way (pick)
  );

  always_comb begin
    vld_d = miss_req;
    way_d = miss_req ? pick : victim_way;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= vld_d;
      victim_way   <= way_d;
    end
  end
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
  import vsel_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_hit,
  input logic [WAY_W-1:0]       req_way,
  input logic                   victim_valid,
  input logic [WAY_W-1:0]       victim_way,
  input logic [WAYS-1:0]        occ_vec,
  input logic [WAYS*RRPV_W-1:0] rrpv_vec
);
  logic [WAYS-1:0]  prev_occ;
  logic             hit_seen;
  logic [WAY_W-1:0] hit_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_occ <= '0;
      hit_seen <= 1'b0;
      hit_way  <= '0;
    end else begin
      prev_occ <= occ_vec;
      hit_seen <= req_valid && req_hit;
      hit_way  <= req_way;
    end
  end

  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hit) |=> victim_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_hit) |=> !victim_valid); // R2
  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !(&prev_occ)) |-> !prev_occ[victim_way]); // R3
  AST_FILL_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> occ_vec[victim_way]); // R7
  AST_FILL_RRPV: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !(hit_seen && hit_way == victim_way))
      |-> rrpv_vec[victim_way*RRPV_W +: RRPV_W] == rrpv_t'(RRPV_INS)); // R7
  AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_seen |-> rrpv_vec[hit_way*RRPV_W +: RRPV_W] == rrpv_t'(RRPV_HIT)); // R6
endmodule

bind vsel_top vsel_checker #(.WAYS(WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q),
  .req_valid    (req_valid),
  .req_hit      (req_hit),
  .req_way      (req_way),
  .victim_valid (victim_valid),
  .victim_way   (victim_way),
  .occ_vec      (way_occ),
  .rrpv_vec     (way_rrpv)
);

// File: tb/sim_vsel_top.sv
`timescale 1ns/1ps
module sim_vsel_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_hit = 1'b0;
  logic [2:0] req_way = '0;
  logic [3:0] req_size = '0;
  logic       victim_valid;
  logic [2:0] victim_way;

  int checks = 0;
  int errors = 0;
  bit m_occ [8];
  int m_cnt [8];
  int m_seg [8];

  always #10 clk = ~clk;

  vsel_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_way(req_way), .req_size(req_size),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int weight(input int c);
    case (c)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int model_victim();
    real best;
    int  bi;
    for (int i = 0; i < 8; i++) if (!m_occ[i]) return i;
    bi = 0;
    best = real'(weight(m_cnt[0])) / real'(m_seg[0]);
    for (int i = 1; i < 8; i++)
      if (real'(weight(m_cnt[i])) / real'(m_seg[i]) < best) begin
        best = real'(weight(m_cnt[i])) / real'(m_seg[i]);
        bi = i;
      end
    return bi;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      m_occ[i] = 1'b0; m_cnt[i] = 0; m_seg[i] = 1;
    end
  endtask

  task automatic miss(input int size, input string req);
    int exp, sz;
    exp = model_victim();
    sz = (size == 0) ? 1 : (size > 8 ? 8 : size);
    req_valid = 1'b1; req_hit = 1'b0; req_size = 4'(size); req_way = 3'(7 - exp);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R2 pulse"}, int'(victim_valid), 1);
    check(req, int'(victim_way), exp);
    m_occ[exp] = 1'b1; m_cnt[exp] = 2; m_seg[exp] = sz;
    @(negedge clk);
    check("R2 single cycle", int'(victim_valid), 0);
  endtask

  task automatic hit(input int way);
    req_valid = 1'b1; req_hit = 1'b1; req_way = 3'(way); req_size = 4'd3;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 hit gives no victim", int'(victim_valid), 0);
    m_cnt[way] = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 victim_valid low", int'(victim_valid), 0);
    miss(3, "R1 empty set picks way 0");
  endtask

  task automatic t_size_order();
    do_reset();
    for (int i = 0; i < 8; i++) miss(i + 1, "R3 R7 fill empty in order");
    miss(1, "R4 largest size evicted");
    hit(6);
    miss(2, "R4 R6 hit way kept");
  endtask

  task automatic t_empty_first();
    do_reset();
    for (int i = 0; i < 3; i++) miss(8, "R3 fill");
    hit(1);
    miss(1, "R3 empty way before valid");
  endtask

  task automatic t_ties();
    do_reset();
    for (int i = 0; i < 8; i++) miss(4, "R7 fill size 4");
    miss(4, "R5 tie lowest index");
    miss(4, "R5 R7 refilled way ties again");
    hit(0);
    miss(4, "R5 R6 next lowest after hit");
  endtask

  task automatic t_cross_tie();
    do_reset();
    miss(8, "R7 fill");
    miss(2, "R7 fill");
    for (int i = 2; i < 8; i++) miss(1, "R7 fill");
    hit(0);
    miss(5, "R4 R5 weight 8/8 ties 2/2");
    miss(5, "R4 next smallest worth");
  endtask

  task automatic t_clamp();
    do_reset();
    for (int i = 0; i < 8; i++) miss(i == 3 ? 12 : 8, "R8 fill");
    miss(2, "R8 oversize stored as 8");
    do_reset();
    for (int i = 0; i < 8; i++) miss(i == 0 ? 0 : 1, "R8 fill");
    miss(2, "R8 zero stored as 1");
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_size_order();
    t_empty_first();
    t_ties();
    t_cross_tie();
    t_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule